// File: doc/BRIEF.md
# Synchronous Shift-Register Expansion Port

This block is a half-duplex synchronous serial port. It adds I/O pins by driving an external shift register. It produces a shift clock and one bidirectional data line, split into an output value, an output enable and an input. A write to the data buffer sends eight bits out, least significant bit first. A pulse that clears the receive flag, while receive is enabled, brings eight bits in. When the byte is finished, the block raises the transmit or receive completion flag.

All timing counts a one-cycle oscillator-period strobe (`osc_tick`). It is not counted against the system clock. The triggering event is the clock edge that accepts the buffer write or the flag clear. Tick 1 is the first strobe seen after that edge. Transmit and receive have fixed tick offsets from that edge. The controller is a four-state machine:

- `ST_IDLE`: the port waits for an event.
- `ST_LEAD`: the port counts lead-in ticks.
- `ST_CLK_LO`: the shift clock is in its low half.
- `ST_CLK_HI`: the shift clock is in its high half.

The transitions are:

- IDLE→LEAD on an accepted event.
- LEAD→CLK_LO when the lead count is reached.
- CLK_LO→CLK_HI on a rising edge that is not the eighth.
- CLK_HI→CLK_LO after a half period.
- CLK_LO→IDLE on the eighth rising edge.

Top module: `sio_expander`

## Requirements
- R1: After reset, `sclk_o` is 1, `sdata_oe` is 0, `sdata_o` is 1, both flags are 0 and `buf_rdata` is 0.
- R2: In idle, a `buf_wr` pulse starts a transmit of `buf_wdata` even when `tx_flag` is already 1. `tx_flag` keeps its value until the transfer completes.
- R3: The shift clock first falls on tick 15 after a transmit event and on tick 18 after a receive event. It then toggles every 6 ticks and makes exactly eight rising edges. After the eighth it stays at 1.
- R4: During a transmit, `sdata_o` is 1 before tick 18. Bit k of the byte (bit 0 first) is presented on tick 18+12k and held until the next bit. `sdata_oe` is 1 from the event until the completing tick.
- R5: In idle with `rx_enable`=1, a `rx_flag_clr` pulse starts a receive. Bit k (bit 0 first) is sampled from `sdata_i` on the rising clock at tick 24+12k. The assembled byte appears on `buf_rdata` when `rx_flag` sets.
- R6: The eighth rising edge sets the flag of its direction. That is tick 105 for transmit and tick 108 for receive.
- R7: A `rx_flag_clr` pulse with `rx_enable`=0 clears `rx_flag` but starts no transfer. The clock stays at 1 and `buf_rdata` is unchanged.
- R8: A `buf_wr` or `rx_flag_clr` arriving during a transfer starts nothing and does not change the bits being shifted.
- R9: A `tx_flag_clr` pulse clears `tx_flag`. A flag being set on the same cycle as its clear takes priority over the clear.
- R10: The data line is released (`sdata_oe`=0) during a receive and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | NBITS | Data to transmit |
| buf_rdata | output | NBITS | Last received byte |
| tx_flag_clr | input | 1 | Clear transmit-complete flag |
| rx_flag_clr | input | 1 | Clear receive-complete flag (also starts a receive) |
| rx_enable | input | 1 | Receive enable level |
| tx_flag | output | 1 | Transmit complete |
| rx_flag | output | 1 | Receive complete |
| sclk_o | output | 1 | Shift clock, idles high |
| sdata_o | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sdata_i | input | 1 | Data line input value |

## Verification
The properties assume that `osc_tick` is a single-cycle strobe. They also assume that the lead-in, half-period and set-up counts obey setup < half period ≤ lead. Under those conditions, clock and data changes can only follow a strobe. The bench starts every event on the cycle after a strobe, so that cycle is never itself a strobe, and it spaces strobes four cycles apart. It changes `sdata_i` only while the shift clock is low, on the tick of a falling edge. That keeps each receive sample well away from a change of the line.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_LO,
        ST_CLK_HI
    } sio_state_e;

    typedef enum logic {
        DIR_TX,
        DIR_RX
    } sio_dir_e;

    function automatic int unsigned sio_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sio_ctrl.sv
`timescale 1ns/1ps
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int TX_LEAD  = 15,
    parameter int RX_LEAD  = 18,
    parameter int HALF_PER = 6,
    parameter int TX_SETUP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic buf_wr,
    input  logic rx_flag_clr,
    input  logic rx_enable,
    output logic sclk,
    output logic busy,
    output logic tx_active,
    output logic load_tx,
    output logic drive_bit,
    output logic sample_bit,
    output logic done_tx,
    output logic done_rx
);

    localparam int CNT_MAX = sio_max(sio_max(TX_LEAD, RX_LEAD), HALF_PER);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = (NBITS > 1) ? $clog2(NBITS) : 1;

    sio_state_e      state, state_d;
    sio_dir_e        dir, dir_d;
    logic [CW-1:0]   cnt, cnt_d, cnt_nx, lead_target;
    logic [BW-1:0]   bitn, bit_d;
    logic            sclk_d;
    logic            start_tx, start_rx;
    logic            lead_hit, half_hit, setup_hit, last_bit;

    // Event decode and tick comparisons shared by both processes
    always_comb begin
        cnt_nx      = cnt + 1'b1;
        lead_target = (dir == DIR_TX) ? CW'(TX_LEAD) : CW'(RX_LEAD);
        lead_hit    = osc_tick && (cnt_nx == lead_target);
        half_hit    = osc_tick && (cnt_nx == CW'(HALF_PER));
        setup_hit   = osc_tick && (cnt_nx == CW'(TX_SETUP));
        last_bit    = (bitn == BW'(NBITS - 1));
        start_tx    = (state == ST_IDLE) && buf_wr;
        start_rx    = (state == ST_IDLE) && !buf_wr && rx_flag_clr && rx_enable;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        dir_d   = dir;
        cnt_d   = cnt;
        bit_d   = bitn;
        sclk_d  = sclk;
        unique case (state)
            ST_IDLE: begin
                if (start_tx || start_rx) begin
                    state_d = ST_LEAD;
                    dir_d   = start_tx ? DIR_TX : DIR_RX;
                    cnt_d   = '0;
                    bit_d   = '0;
                end
            end
            ST_LEAD: begin
                if (lead_hit) begin
                    state_d = ST_CLK_LO;
                    sclk_d  = 1'b0;
                    cnt_d   = '0;
                end else if (osc_tick) begin
                    cnt_d = cnt_nx;
                end
            end
            ST_CLK_LO: begin
                if (half_hit) begin
                    sclk_d = 1'b1;
                    cnt_d  = '0;
                    if (last_bit) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_CLK_HI;
                        bit_d   = bitn + 1'b1;
                    end
                end else if (osc_tick) begin
                    cnt_d = cnt_nx;
                end
            end
            ST_CLK_HI: begin
                if (half_hit) begin
                    state_d = ST_CLK_LO;
                    sclk_d  = 1'b0;
                    cnt_d   = '0;
                end else if (osc_tick) begin
                    cnt_d = cnt_nx;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dir   <= DIR_TX;
            cnt   <= '0;
            bitn  <= '0;
            sclk  <= 1'b1;
        end else begin
            state <= state_d;
            dir   <= dir_d;
            cnt   <= cnt_d;
            bitn  <= bit_d;
            sclk  <= sclk_d;
        end
    end

    // Output strobes
    always_comb begin
        busy       = (state != ST_IDLE);
        tx_active  = busy && (dir == DIR_TX);
        load_tx    = start_tx;
        drive_bit  = (state == ST_CLK_LO) && (dir == DIR_TX) && setup_hit;
        sample_bit = (state == ST_CLK_LO) && (dir == DIR_RX) && half_hit;
        done_tx    = (state == ST_CLK_LO) && (dir == DIR_TX) && half_hit && last_bit;
        done_rx    = (state == ST_CLK_LO) && (dir == DIR_RX) && half_hit && last_bit;
    end

endmodule

// File: rtl/sio_shifter.sv
`timescale 1ns/1ps
module sio_shifter #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] load_data,
    input  logic             drive_bit,
    input  logic             sample_bit,
    input  logic             sdata_i,
    output logic             sdata_o,
    output logic [NBITS-1:0] capture
);

    logic [NBITS-1:0] shreg;

    // Byte as it stands once the current input sample is taken
    assign capture = {sdata_i, shreg[NBITS-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            sdata_o <= 1'b1;
        end else if (load) begin
            shreg   <= load_data;
            sdata_o <= 1'b1;
        end else if (drive_bit) begin
            sdata_o <= shreg[0];
            shreg   <= {1'b0, shreg[NBITS-1:1]};
        end else if (sample_bit) begin
            shreg   <= capture;
        end
    end

endmodule

// File: rtl/sio_flags.sv
`timescale 1ns/1ps
module sio_flags #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_tx,
    input  logic             done_rx,
    input  logic             tx_flag_clr,
    input  logic             rx_flag_clr,
    input  logic [NBITS-1:0] capture,
    output logic             tx_flag,
    output logic             rx_flag,
    output logic [NBITS-1:0] rx_buf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
            rx_buf  <= '0;
        end else begin
            if (done_tx) begin
                tx_flag <= 1'b1;
            end else if (tx_flag_clr) begin
                tx_flag <= 1'b0;
            end
            if (done_rx) begin
                rx_flag <= 1'b1;
                rx_buf  <= capture;
            end else if (rx_flag_clr) begin
                rx_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sio_expander.sv
`timescale 1ns/1ps
module sio_expander #(
    parameter int NBITS    = 8,
    parameter int TX_LEAD  = 15,
    parameter int RX_LEAD  = 18,
    parameter int HALF_PER = 6,
    parameter int TX_SETUP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             buf_wr,
    input  logic [NBITS-1:0] buf_wdata,
    output logic [NBITS-1:0] buf_rdata,
    input  logic             tx_flag_clr,
    input  logic             rx_flag_clr,
    input  logic             rx_enable,
    output logic             tx_flag,
    output logic             rx_flag,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             sdata_oe,
    input  logic             sdata_i
);

    logic             busy, tx_active, load_tx, drive_bit, sample_bit;
    logic             done_tx, done_rx;
    logic [NBITS-1:0] capture;

    sio_ctrl #(
        .NBITS    (NBITS),
        .TX_LEAD  (TX_LEAD),
        .RX_LEAD  (RX_LEAD),
        .HALF_PER (HALF_PER),
        .TX_SETUP (TX_SETUP)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .buf_wr      (buf_wr),
        .rx_flag_clr (rx_flag_clr),
        .rx_enable   (rx_enable),
        .sclk        (sclk_o),
        .busy        (busy),
        .tx_active   (tx_active),
        .load_tx     (load_tx),
        .drive_bit   (drive_bit),
        .sample_bit  (sample_bit),
        .done_tx     (done_tx),
        .done_rx     (done_rx)
    );

    sio_shifter #(.NBITS(NBITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_tx),
        .load_data  (buf_wdata),
        .drive_bit  (drive_bit),
        .sample_bit (sample_bit),
        .sdata_i    (sdata_i),
        .sdata_o    (sdata_o),
        .capture    (capture)
    );

    sio_flags #(.NBITS(NBITS)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_tx     (done_tx),
        .done_rx     (done_rx),
        .tx_flag_clr (tx_flag_clr),
        .rx_flag_clr (rx_flag_clr),
        .capture     (capture),
        .tx_flag     (tx_flag),
        .rx_flag     (rx_flag),
        .rx_buf      (buf_rdata)
    );

    assign sdata_oe = tx_active;

endmodule

// File: rtl/sio_expander_chk.sv
`timescale 1ns/1ps
module sio_expander_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_tick,
    input logic buf_wr,
    input logic rx_flag_clr,
    input logic rx_enable,
    input logic busy,
    input logic sclk_o,
    input logic sdata_o,
    input logic sdata_oe,
    input logic tx_flag,
    input logic rx_flag
);

    assert_sclk_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(sclk_o));

    assert_sclk_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> busy);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !(buf_wr && !busy)) |=> $stable(sdata_o));

    assert_start_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !busy) |=> (busy && sdata_oe));

    assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> busy);

    assert_txflag_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> $rose(sclk_o));

    assert_rxflag_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $rose(sclk_o));

    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rx_flag_clr && !rx_enable && !buf_wr) |=> !busy);

endmodule

bind sio_expander sio_expander_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .buf_wr      (buf_wr),
    .rx_flag_clr (rx_flag_clr),
    .rx_enable   (rx_enable),
    .busy        (busy),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .sdata_oe    (sdata_oe),
    .tx_flag     (tx_flag),
    .rx_flag     (rx_flag)
);

// File: tb/sio_expander_tb_top.sv
`timescale 1ns/1ps
module sio_expander_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [1:0] div = 2'd0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_rdata;
    logic       tx_flag_clr = 1'b0;
    logic       rx_flag_clr = 1'b0;
    logic       rx_enable = 1'b0;
    logic       tx_flag, rx_flag, sclk_o, sdata_o, sdata_oe;
    logic       sdata_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // One-cycle strobe every fourth clock, changed away from the rising edge
    always @(negedge clk) begin
        div      <= div + 2'd1;
        osc_tick <= (div == 2'd3);
    end

    sio_expander dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .buf_wr      (buf_wr),
        .buf_wdata   (buf_wdata),
        .buf_rdata   (buf_rdata),
        .tx_flag_clr (tx_flag_clr),
        .rx_flag_clr (rx_flag_clr),
        .rx_enable   (rx_enable),
        .tx_flag     (tx_flag),
        .rx_flag     (rx_flag),
        .sclk_o      (sclk_o),
        .sdata_o     (sdata_o),
        .sdata_oe    (sdata_oe),
        .sdata_i     (sdata_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Returns at the falling edge following a clock edge that carried a strobe
    task automatic wait_tick();
        do @(posedge clk); while (osc_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic run_xfer(input bit is_tx, input logic [7:0] val, input bit en,
                            input int inj_at, input int ntick);
        bit         prev_tx, prev_rx, active, exp_sclk, exp_tx, exp_rx;
        logic [7:0] prev_rd;
        int         lead, m, idx;
        string      sreq;
        prev_tx = tx_flag;
        prev_rx = rx_flag;
        prev_rd = buf_rdata;
        wait_tick();
        if (is_tx) begin
            buf_wdata = val;
            buf_wr    = 1'b1;
        end else begin
            rx_enable   = en;
            rx_flag_clr = 1'b1;
        end
        @(negedge clk);
        buf_wr      = 1'b0;
        rx_flag_clr = 1'b0;
        active = is_tx || en;
        lead   = is_tx ? 15 : 18;
        for (int n = 1; n <= ntick; n++) begin
            wait_tick();
            m = n - lead;
            exp_sclk = !(active && n >= lead && m < 90 && ((m / 6) % 2 == 0));
            sreq = active ? "R3 sclk" : "R7 sclk idle";
            chk(sreq, int'(sclk_o), int'(exp_sclk));
            if (is_tx) begin
                chk("R4 oe", int'(sdata_oe), int'(n < 105));
                if (n < 105) begin
                    idx = (n - 18) / 12;
                    chk("R4 data", int'(sdata_o), (n < 18) ? 1 : int'(val[idx]));
                end
                exp_tx = prev_tx || (n >= 105);
                chk(prev_tx ? "R2 tx_flag held" : "R6 tx_flag", int'(tx_flag), int'(exp_tx));
                chk("R8 rx_flag untouched", int'(rx_flag), int'(prev_rx));
            end else begin
                chk("R10 oe released", int'(sdata_oe), 0);
                exp_rx = en && (n >= 108);
                chk(en ? "R6 rx_flag" : "R7 rx_flag", int'(rx_flag), int'(exp_rx));
                if (n >= 18 && (n - 18) % 12 == 0 && (n - 18) / 12 < 8)
                    sdata_i = val[(n - 18) / 12];
            end
            if (n == inj_at) begin
                buf_wdata = ~val;
                buf_wr    = 1'b1;
                if (is_tx) begin
                    rx_enable   = 1'b1;
                    rx_flag_clr = 1'b1;
                end
                @(negedge clk);
                buf_wr      = 1'b0;
                rx_flag_clr = 1'b0;
                if (is_tx) prev_rx = 1'b0;
            end
        end
        if (!is_tx) begin
            chk(en ? "R5 rx byte" : "R7 rx buffer kept", int'(buf_rdata),
                en ? int'(val) : int'(prev_rd));
        end
    endtask

    initial begin
        logic [7:0] pats [8];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
        repeat (5) @(negedge clk);
        chk("R1 sclk", int'(sclk_o), 1);
        chk("R1 oe", int'(sdata_oe), 0);
        chk("R1 data", int'(sdata_o), 1);
        chk("R1 tx_flag", int'(tx_flag), 0);
        chk("R1 rx_flag", int'(rx_flag), 0);
        chk("R1 rdata", int'(buf_rdata), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R6: transmit sweep, flag left set between bytes
        foreach (pats[i]) run_xfer(1'b1, pats[i], 1'b0, 0, 112);
        for (int k = 0; k < 8; k++) run_xfer(1'b1, 8'(1 << k), 1'b0, 0, 110);

        // R9: clear the transmit flag
        tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;
        @(negedge clk);
        chk("R9 tx_flag clear", int'(tx_flag), 0);

        // R8: write and receive start during a transmit are ignored
        run_xfer(1'b1, 8'h96, 1'b0, 50, 150);

        // R5 R6 R10: receive sweep
        foreach (pats[i]) run_xfer(1'b0, pats[i], 1'b1, 0, 112);
        for (int k = 0; k < 8; k++) run_xfer(1'b0, 8'(~(1 << k)), 1'b1, 0, 110);

        // R8: buffer write during a receive is ignored
        run_xfer(1'b0, 8'h6B, 1'b1, 60, 150);

        // R7: receive disabled
        run_xfer(1'b0, 8'h11, 1'b0, 0, 120);
        chk("R7 rx buffer still last byte", int'(buf_rdata), 8'h6B);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule